// File: doc/BRIEF.md
# Flash-to-Flash Page Copy Sequencer

This block duplicates the whole contents of one NAND flash device onto a second device of the same geometry. Both devices sit on one shared set of data and control lines. Each has its own active-low chip enable, and the sequencer drives at most one of them low at a time. The sequencer does not toggle the flash pins itself. It hands one command at a time to a NAND bus controller and waits for that controller to report completion. The command carries an opcode, a page or block address, a half-page pointer and a byte count. The bus controller's chip-select input is driven from this block's two enable outputs.

A copy starts with a one-cycle start pulse. The sequencer first erases every block of the target, in ascending order, and reads status after each erase. It then walks the pages in ascending order. For each page it reads the first half of the source page into the bus controller and loads it into the target's page register. It does the same for the second half, which includes the spare bytes, and then issues one program command to commit the page. After each erase or program it waits for ready/busy to return high, then reads the target status.

A failing status stops the copy, raises error and records the failing page index. Busy is high for as long as a copy is in progress. Done pulses once when the last page has been committed and its status has been read as passing. Block count, pages per block, half-page size and spare size are parameters, so a simulation can use a small array.

Top module: `flashCopySeq`

## Requirements
- R1: The chip enable pair ceN (bit 0 is the source device, bit 1 is the target device, active low) never has both bits low. Both bits are high whenever cmdValid is low. A read command selects only the source (ceN = 2'b10). Every other command selects only the target (ceN = 2'b01).
- R2: After start, the first commands are, for each block b = 0 .. BLOCKS-1 in ascending order, an erase (cmdOp = 0) with cmdAddr = b*PAGES_PER_BLOCK, followed by a status read (cmdOp = 4). No read is issued before the last block's status has passed.
- R3: Pages are copied in ascending order from 0 to BLOCKS*PAGES_PER_BLOCK-1. Page n is read from source page n and loaded, programmed and committed into target page n, so cmdAddr = n for each of these commands.
- R4: Each page uses exactly this command order: read with cmdPtr = 0 (cmdOp = 1), load with cmdPtr = 0 (cmdOp = 2), read with cmdPtr = 1, load with cmdPtr = 1, one program (cmdOp = 3), and one status read (cmdOp = 4).
- R5: For reads and loads, cmdLen is HALF_BYTES when cmdPtr = 0 and HALF_BYTES+SPARE_BYTES when cmdPtr = 1, so a whole page including the spare area moves (256 and 272 bytes with the default values).
- R6: Once cmdValid is high, it stays high with cmdOp, cmdAddr and cmdPtr unchanged until the cycle in which cmdDone is sampled high.
- R7: After an erase or program completes, no command is issued while rbN is low. The bus controller drives rbN low no later than the cmdDone of that command. The next command, issued once rbN is high, is a status read.
- R8: A status read that returns statusFail = 1 with its cmdDone ends the copy. In the following cycle busy is low, error is high and no further command is issued. failPage holds the failing page, or for a failed erase the first page of the failed block.
- R9: When the last page's status passes, done is high for exactly one cycle. In that same cycle busy is low and error is low.
- R10: A start pulse while idle raises busy in the next cycle, clears error and failPage, and restarts the copy from block 0. A start pulse while busy is ignored.
- R11: During and after reset, busy, done, error and cmdValid are low, ceN is 2'b11 and failPage is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a copy |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Sticky failure flag, cleared by start |
| failPage | output | PAGE_W | Page index of the failure |
| cmdValid | output | 1 | Command request to the NAND bus controller |
| cmdOp | output | 3 | 0 erase, 1 read, 2 load, 3 program, 4 status |
| cmdAddr | output | PAGE_W | Page index (first page of the block for an erase) |
| cmdPtr | output | 1 | Half-page pointer: 0 first half, 1 second half plus spare |
| cmdLen | output | LEN_W | Byte count for a read or load |
| cmdDone | input | 1 | Controller finished the current command |
| statusFail | input | 1 | Failure bit of a status read, valid with cmdDone |
| rbN | input | 1 | Shared ready/busy line, low while a device is busy |
| ceN | output | 2 | Active-low chip enables: bit 0 source, bit 1 target |

## Verification
A wrong page or block counter shows at the ports on the very next command, as a wrong cmdAddr. A wrong half pointer shows as a repeated or missing half with the wrong cmdLen on the next read or load. A control state that skips a step shows as an opcode out of the six-command page pattern, at most one command later. A control state that ignores rbN issues a command while the line is still low. A wrong completion or failure path shows within one cycle of the final status read, as a missing or doubled done pulse, a done with error set, or a failPage that does not match the status read that failed.

// File: rtl/flashCopyPkg.sv
package flashCopyPkg;

  // Command opcodes handed to the NAND bus controller
  typedef enum logic [2:0] {
    OP_ERASE  = 3'd0,
    OP_READ   = 3'd1,
    OP_LOAD   = 3'd2,
    OP_PROG   = 3'd3,
    OP_STATUS = 3'd4
  } seqOp_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   issue;        // a command is presented this cycle
    seqOp_t op;           // which command
    logic   clrAll;       // begin a new copy
    logic   incBlk;       // next erase block
    logic   incPage;      // next page
    logic   setPtr;       // switch to second half
    logic   clrPtr;       // back to first half
    logic   latchFail;    // record a failing status
    logic   failIsErase;  // failure came from an erase
    logic   pulseDone;    // successful completion
  } seqStrobe_t;

endpackage

// File: rtl/flashCopyCtrl.sv
module flashCopyCtrl
  import flashCopyPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cmdDone,
  input  logic       statusFail,
  input  logic       rbN,
  input  logic       lastBlk,
  input  logic       lastPage,
  input  logic       ptrHi,
  output seqStrobe_t st,
  output logic       busy
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_ER_CMD,
    S_ER_BUSY,
    S_ER_STAT,
    S_RD,
    S_LD,
    S_PG_CMD,
    S_PG_BUSY,
    S_PG_STAT
  } ctrlState_t;

  ctrlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    st        = '0;
    st.op     = OP_ERASE;
    nextState = state;
    busy      = (state != S_IDLE);
    case (state)
      S_IDLE: begin
        if (start) begin
          st.clrAll = 1'b1;
          nextState = S_ER_CMD;
        end
      end
      S_ER_CMD: begin
        st.issue = 1'b1;
        st.op    = OP_ERASE;
        if (cmdDone) nextState = S_ER_BUSY;
      end
      S_ER_BUSY: begin
        if (rbN) nextState = S_ER_STAT;
      end
      S_ER_STAT: begin
        st.issue = 1'b1;
        st.op    = OP_STATUS;
        if (cmdDone) begin
          if (statusFail) begin
            st.latchFail   = 1'b1;
            st.failIsErase = 1'b1;
            nextState      = S_IDLE;
          end else if (lastBlk) begin
            nextState = S_RD;
          end else begin
            st.incBlk = 1'b1;
            nextState = S_ER_CMD;
          end
        end
      end
      S_RD: begin
        st.issue = 1'b1;
        st.op    = OP_READ;
        if (cmdDone) nextState = S_LD;
      end
      S_LD: begin
        st.issue = 1'b1;
        st.op    = OP_LOAD;
        if (cmdDone) begin
          if (ptrHi) begin
            nextState = S_PG_CMD;
          end else begin
            st.setPtr = 1'b1;
            nextState = S_RD;
          end
        end
      end
      S_PG_CMD: begin
        st.issue = 1'b1;
        st.op    = OP_PROG;
        if (cmdDone) nextState = S_PG_BUSY;
      end
      S_PG_BUSY: begin
        if (rbN) nextState = S_PG_STAT;
      end
      S_PG_STAT: begin
        st.issue = 1'b1;
        st.op    = OP_STATUS;
        if (cmdDone) begin
          if (statusFail) begin
            st.latchFail = 1'b1;
            nextState    = S_IDLE;
          end else if (lastPage) begin
            st.pulseDone = 1'b1;
            nextState    = S_IDLE;
          end else begin
            st.incPage = 1'b1;
            st.clrPtr  = 1'b1;
            nextState  = S_RD;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/flashCopyPath.sv
module flashCopyPath
  import flashCopyPkg::*;
#(
  parameter int BLOCKS          = 1024,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int HALF_BYTES      = 256,
  parameter int SPARE_BYTES     = 16,
  localparam int BLK_W  = $clog2(BLOCKS),
  localparam int PPB_W  = $clog2(PAGES_PER_BLOCK),
  localparam int PAGE_W = BLK_W + PPB_W,
  localparam int LEN_W  = $clog2(HALF_BYTES + SPARE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  output logic [PAGE_W-1:0] cmdAddr,
  output logic              cmdPtr,
  output logic [LEN_W-1:0]  cmdLen,
  output logic [1:0]        ceN,
  output logic              lastBlk,
  output logic              lastPage,
  output logic              ptrHi,
  output logic              error,
  output logic [PAGE_W-1:0] failPage,
  output logic              done
);

  localparam int PAGES = BLOCKS * PAGES_PER_BLOCK;

  logic [BLK_W-1:0]  blk;
  logic [PAGE_W-1:0] page;
  logic              ptr;
  logic [PAGE_W-1:0] blkBase;

  assign blkBase = {blk, {PPB_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blk      <= '0;
      page     <= '0;
      ptr      <= 1'b0;
      error    <= 1'b0;
      failPage <= '0;
      done     <= 1'b0;
    end else begin
      done <= st.pulseDone;
      if (st.clrAll) begin
        blk      <= '0;
        page     <= '0;
        ptr      <= 1'b0;
        error    <= 1'b0;
        failPage <= '0;
      end
      if (st.incBlk)  blk  <= blk + BLK_W'(1);
      if (st.incPage) page <= page + PAGE_W'(1);
      if (st.setPtr)  ptr  <= 1'b1;
      if (st.clrPtr)  ptr  <= 1'b0;
      if (st.latchFail) begin
        error    <= 1'b1;
        failPage <= st.failIsErase ? blkBase : page;
      end
    end
  end

  assign lastBlk  = (blk == BLK_W'(BLOCKS - 1));
  assign lastPage = (page == PAGE_W'(PAGES - 1));
  assign ptrHi    = ptr;
  assign cmdPtr   = ptr;
  assign cmdAddr  = (st.op == OP_ERASE) ? blkBase : page;
  assign cmdLen   = ptr ? LEN_W'(HALF_BYTES + SPARE_BYTES) : LEN_W'(HALF_BYTES);

  // Reads address the source device, everything else the target
  always_comb begin
    ceN = 2'b11;
    if (st.issue) begin
      if (st.op == OP_READ) ceN = 2'b10;
      else                  ceN = 2'b01;
    end
  end

endmodule

// File: rtl/flashCopySeq.sv
module flashCopySeq
  import flashCopyPkg::*;
#(
  parameter int BLOCKS          = 1024,
  parameter int PAGES_PER_BLOCK = 16,
  parameter int HALF_BYTES      = 256,
  parameter int SPARE_BYTES     = 16,
  localparam int PAGE_W = $clog2(BLOCKS) + $clog2(PAGES_PER_BLOCK),
  localparam int LEN_W  = $clog2(HALF_BYTES + SPARE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [PAGE_W-1:0] failPage,
  output logic              cmdValid,
  output logic [2:0]        cmdOp,
  output logic [PAGE_W-1:0] cmdAddr,
  output logic              cmdPtr,
  output logic [LEN_W-1:0]  cmdLen,
  input  logic              cmdDone,
  input  logic              statusFail,
  input  logic              rbN,
  output logic [1:0]        ceN
);

  seqStrobe_t st;
  logic lastBlk, lastPage, ptrHi;

  flashCopyCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .cmdDone    (cmdDone),
    .statusFail (statusFail),
    .rbN        (rbN),
    .lastBlk    (lastBlk),
    .lastPage   (lastPage),
    .ptrHi      (ptrHi),
    .st         (st),
    .busy       (busy)
  );

  flashCopyPath #(
    .BLOCKS          (BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .HALF_BYTES      (HALF_BYTES),
    .SPARE_BYTES     (SPARE_BYTES)
  ) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .cmdAddr  (cmdAddr),
    .cmdPtr   (cmdPtr),
    .cmdLen   (cmdLen),
    .ceN      (ceN),
    .lastBlk  (lastBlk),
    .lastPage (lastPage),
    .ptrHi    (ptrHi),
    .error    (error),
    .failPage (failPage),
    .done     (done)
  );

  assign cmdValid = st.issue;
  assign cmdOp    = st.op;

endmodule

// File: rtl/flashCopyChk.sv
module flashCopyChk #(
  parameter int PAGE_W = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic [PAGE_W-1:0] cmdAddr,
  input logic              cmdPtr,
  input logic              cmdDone,
  input logic              rbN,
  input logic [1:0]        ceN
);

  // R1
  one_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~ceN) <= 1);

  // R1
  idle_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> ceN == 2'b11);

  // R1
  active_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ceN != 2'b11);

  // R6
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(cmdOp) && $stable(cmdAddr) && $stable(cmdPtr)));

  // R7
  rb_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rbN && !cmdValid) |=> (rbN || !cmdValid));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !cmdValid && !busy);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !error));

endmodule

bind flashCopySeq flashCopyChk #(.PAGE_W(PAGE_W)) i_flashCopyChk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .error    (error),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdAddr  (cmdAddr),
  .cmdPtr   (cmdPtr),
  .cmdDone  (cmdDone),
  .rbN      (rbN),
  .ceN      (ceN)
);

// File: tb/test_flashCopySeq.sv
module test_flashCopySeq;

  localparam int BLK    = 4;
  localparam int PPB    = 16;
  localparam int HALF   = 256;
  localparam int SPARE  = 16;
  localparam int PAGES  = BLK * PPB;
  localparam int PAGE_W = $clog2(BLK) + $clog2(PPB);
  localparam int LEN_W  = $clog2(HALF + SPARE + 1);
  localparam int TOTAL  = 2 * BLK + 6 * PAGES;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic              busy, done, error;
  logic [PAGE_W-1:0] failPage;
  logic              cmdValid;
  logic [2:0]        cmdOp;
  logic [PAGE_W-1:0] cmdAddr;
  logic              cmdPtr;
  logic [LEN_W-1:0]  cmdLen;
  logic              cmdDone, statusFail, rbN;
  logic [1:0]        ceN;

  int checks = 0;
  int errs   = 0;
  int idx    = 0;
  int failAt = -1;

  always #4 clk = ~clk;  // 125 MHz

  flashCopySeq #(
    .BLOCKS(BLK), .PAGES_PER_BLOCK(PPB), .HALF_BYTES(HALF), .SPARE_BYTES(SPARE)
  ) i_flashCopySeq (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .error(error),
    .failPage(failPage), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdPtr(cmdPtr), .cmdLen(cmdLen), .cmdDone(cmdDone), .statusFail(statusFail),
    .rbN(rbN), .ceN(ceN)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected command stream, from the requirements
  function automatic int expOp(int i);
    int k;
    if (i < 2 * BLK) return (i % 2 == 0) ? 0 : 4;
    k = (i - 2 * BLK) % 6;
    if (k == 0 || k == 2) return 1;
    if (k == 1 || k == 3) return 2;
    if (k == 4) return 3;
    return 4;
  endfunction

  function automatic int expAddr(int i);
    if (i < 2 * BLK) return (i / 2) * PPB;
    return (i - 2 * BLK) / 6;
  endfunction

  function automatic int expPtr(int i);
    int k;
    k = (i - 2 * BLK) % 6;
    return (k == 2 || k == 3) ? 1 : 0;
  endfunction

  function automatic int statusIdxOfPage(int p);
    return 2 * BLK + 6 * p + 5;
  endfunction

  // Bus controller model
  initial begin : responder
    cmdDone    = 1'b0;
    statusFail = 1'b0;
    rbN        = 1'b1;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && cmdValid === 1'b1) begin
        int eop, lat, nrb;
        bit useAddr, useHalf, busyOp;
        logic [31:0] act, exp;
        string tag;
        eop     = expOp(idx);
        useAddr = (eop <= 3);
        useHalf = (eop == 1 || eop == 2);
        act = {8'(cmdOp), 4'(ceN), useAddr ? 10'(cmdAddr) : 10'd0,
               useHalf ? 1'(cmdPtr) : 1'b0, useHalf ? 9'(cmdLen) : 9'd0};
        exp = {8'(eop), (eop == 1) ? 4'b0010 : 4'b0001, useAddr ? 10'(expAddr(idx)) : 10'd0,
               useHalf ? 1'(expPtr(idx)) : 1'b0,
               useHalf ? ((expPtr(idx) == 1) ? 9'(HALF + SPARE) : 9'(HALF)) : 9'd0};
        if (idx < 2 * BLK) tag = "R2 R1 erase phase";
        else if (useHalf)  tag = "R3 R4 R5 R1 half transfer";
        else               tag = "R3 R4 R7 commit/status";
        check(act == exp, tag, act, exp);
        lat = $urandom_range(0, 3);
        repeat (lat) @(negedge clk);
        busyOp     = (cmdOp == 3'd0 || cmdOp == 3'd3);
        cmdDone    = 1'b1;
        statusFail = (cmdOp == 3'd4 && idx == failAt);
        if (busyOp) rbN = 1'b0;
        idx++;
        @(negedge clk);
        cmdDone    = 1'b0;
        statusFail = 1'b0;
        if (busyOp) begin
          nrb = $urandom_range(1, 6);
          for (int j = 0; j < nrb; j++) begin
            check(cmdValid == 1'b0, "R7 no command while rbN low", cmdValid, 0);
            @(negedge clk);
          end
          rbN = 1'b1;
        end
      end
    end
  end

  // Pulse start and wait for the run to end; returns the number of done cycles
  task automatic runCopy(input bit spam, output int nDone);
    nDone = 0;
    @(negedge clk);
    idx   = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    check(error == 1'b0 && failPage == '0, "R10 start clears error", {error, failPage}, 0);
    for (int c = 0; c < 40000; c++) begin
      @(negedge clk);
      if (done) nDone++;
      if (!busy) begin
        start = 1'b0;
        break;
      end
      start = spam && ($urandom_range(0, 30) == 0);
    end
  endtask

  task automatic expectSuccess(input int nDone, input string what);
    check(nDone == 1, {"R9 single done ", what}, nDone, 1);
    check(done == 1'b1 && error == 1'b0, "R9 done without error", {done, error}, 2'b10);
    check(idx == TOTAL, "R3 all pages copied", idx, TOTAL);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic expectFail(input int nDone, input int page, input int nCmds);
    check(nDone == 0, "R8 no done on failure", nDone, 0);
    check(error == 1'b1, "R8 error raised", error, 1);
    check(failPage == PAGE_W'(page), "R8 failing page", failPage, page);
    repeat (20) @(negedge clk);
    check(idx == nCmds && cmdValid == 1'b0, "R8 no further commands", idx, nCmds);
    check(error == 1'b1 && busy == 1'b0, "R8 error sticky", {error, busy}, 2'b10);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin : main
    int nd, p;
    void'($urandom(32'h5eed_f1a5));
    rstN  = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, done, error, cmdValid} == 4'b0, "R11 reset flags", {busy, done, error, cmdValid}, 0);
    check(ceN == 2'b11 && failPage == '0, "R11 reset enables/failPage", {ceN, failPage}, 2'b11 << PAGE_W);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && cmdValid == 1'b0, "R11 idle after reset", {busy, cmdValid}, 0);

    // Full copy
    failAt = -1;
    runCopy(1'b0, nd);
    expectSuccess(nd, "plain run");

    // Erase failure at block 2: failPage is its first page
    failAt = 2 * 2 + 1;
    runCopy(1'b0, nd);
    expectFail(nd, 2 * PPB, failAt + 1);

    // Restart after error, program failure at page 37
    failAt = statusIdxOfPage(37);
    runCopy(1'b0, nd);
    expectFail(nd, 37, failAt + 1);

    // Last-block erase failure boundary
    failAt = 2 * (BLK - 1) + 1;
    runCopy(1'b0, nd);
    expectFail(nd, (BLK - 1) * PPB, failAt + 1);

    // Full copy with start pulses while busy (R10: ignored)
    failAt = -1;
    runCopy(1'b1, nd);
    expectSuccess(nd, "R10 start while busy");

    // Failure on the final page
    failAt = statusIdxOfPage(PAGES - 1);
    runCopy(1'b0, nd);
    expectFail(nd, PAGES - 1, failAt + 1);

    // Random program failures
    for (int r = 0; r < 3; r++) begin
      p = $urandom_range(0, PAGES - 1);
      failAt = statusIdxOfPage(p);
      runCopy(r == 1, nd);
      expectFail(nd, p, failAt + 1);
    end

    // Final clean run after failures
    failAt = -1;
    runCopy(1'b0, nd);
    expectSuccess(nd, "after failures");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

endmodule